// File: doc/BRIEF.md
# Protected GPIO Pin Configuration Bank

This block keeps the configuration of one 8-pin GPIO port. For every pin it stores four control bits: digital enable, weak pull-up enable, alternate-function select and core select. These drive the pad logic directly. The digital enable bit also gates the pad's output driver and input receiver. Out of reset every bit is 0, so each pin is a tri-stated GPIO with its receiver blocked.

Software reaches the bank through two write paths and one combinational read port. The peripheral path places each write in a staging register, so the write lands one clock later than a write on the system path. The system path updates the bank on the clock edge that samples the write.

Pin 7 carries a critical signal and is protected. A write to its bit in any of the four configuration registers is kept only when two conditions hold: the unlock key has been written to the key register, and bit 7 of the commit mask is set. The commit mask can itself be changed only while the bank is unlocked.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, all four configuration registers, the commit mask and every pad control output are 0, and reading the key register returns 1 (locked).
- R2: Asserting either `por_n` or `ext_rst_n` low returns every configuration register, the commit mask and the lock state to the R1 defaults.
- R3: `pad_in_en` is 1 only for pins whose digital enable bit is 1. `pad_drv_en` is 1 only where the digital enable bit and `core_oe` are both 1. A pin whose digital enable bit is 0 has both outputs at 0.
- R4: `pad_pu_en` follows the pull-up enable register bit for bit.
- R5: The register index map is 0 digital enable, 1 pull-up enable, 2 alternate-function select, 3 core select, 4 key, 5 commit mask. Configuration registers hold bits 7:0 only, and bits 31:8 read as 0. Indexes 6 and 7 read as 0.
- R6: Writing 0x4C4F434B to index 4 unlocks the bank, and index 4 then reads 0. Writing any other value locks it, and index 4 then reads 1.
- R7: A write to the commit mask takes effect only while the bank is unlocked. Otherwise the mask keeps its value.
- R8: Bit 7 of any configuration register changes on a write only when the bank is unlocked and bit 7 of the commit mask is 1.
- R9: Bits 6:0 of a configuration register take the written data on every write, including a write whose bit 7 is discarded.
- R10: A system-path write is visible on the outputs and the read port right after the clock edge that samples it.
- R11: A peripheral-path write is not visible after the edge that samples it. It is visible after the following edge.
- R12: When a staged peripheral write and a system write apply on the same edge, the peripheral write is applied first. The system write sees the lock and commit state that the peripheral write leaves, and the system write wins on any bit both touch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| pb_we | input | 1 | Peripheral-path write strobe |
| pb_addr | input | 3 | Peripheral-path register index |
| pb_wdata | input | 32 | Peripheral-path write data |
| sb_we | input | 1 | System-path write strobe |
| sb_addr | input | 3 | System-path register index |
| sb_wdata | input | 32 | System-path write data |
| rd_addr | input | 3 | Read register index |
| rd_data | output | 32 | Read data, combinational from stored state |
| core_oe | input | 8 | Per-pin output-enable request from the selected function |
| cfg_den | output | 8 | Digital enable bits |
| cfg_pue | output | 8 | Weak pull-up enable bits |
| cfg_afsel | output | 8 | Alternate-function select bits |
| cfg_csel | output | 8 | Core select bits |
| pad_drv_en | output | 8 | Pad output driver enable |
| pad_in_en | output | 8 | Pad input receiver enable |
| pad_pu_en | output | 8 | Pad weak pull-up enable |

## Verification
The bench tries pin 7 under all four combinations of lock state and commit bit, on all four configuration registers. A design that checks only one of the two conditions would let bit 7 change while the bank is locked, or while the commit bit is clear. The bench also clears the low bits in a write whose bit 7 is discarded, which catches a design that throws away the whole word.

On the two paths, the bench samples between the first and second edge after a write. A design that skipped the staging stage, or staged the system path as well, would show the new value one cycle early or one cycle late.

For the same-edge case, the bench unlocks through the peripheral path just before a system write to bit 7. A design that merged the two writes in the wrong order would discard that bit, or let the peripheral data overwrite the system data.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RI_DEN    = 3'd0,
        RI_PUE    = 3'd1,
        RI_AFS    = 3'd2,
        RI_CSEL   = 3'd3,
        RI_LOCK   = 3'd4,
        RI_COMMIT = 3'd5
    } reg_idx_e;

endpackage

// File: rtl/gpio_cfg_stage.sv
// Holds one peripheral-path write for a clock so that it lands one edge later.
module gpio_cfg_stage #(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_we,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } stg_t;

    stg_t stg_d, stg_q;

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = in_we;
        if (in_we) begin
            stg_d.addr = in_addr;
            stg_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_vld  = stg_q.vld;
    assign out_addr = stg_q.addr;
    assign out_data = stg_q.data;

endmodule

// File: rtl/gpio_cfg_guard.sv
// Merges write data with the old bits, holding protected bits unless released.
module gpio_cfg_guard #(
    parameter int unsigned            NPINS     = 8,
    parameter logic [NPINS-1:0]       PROT_MASK = 8'h80
) (
    input  logic [NPINS-1:0] old_bits,
    input  logic [NPINS-1:0] new_bits,
    input  logic [NPINS-1:0] commit,
    input  logic             unlocked,
    output logic [NPINS-1:0] merged
);

    for (genvar g = 0; g < NPINS; g++) begin : g_bit
        assign merged[g] = (PROT_MASK[g] && !(unlocked && commit[g]))
                           ? old_bits[g] : new_bits[g];
    end

endmodule

// File: rtl/gpio_cfg_pad.sv
// Per-pin derivation of pad driver, receiver and pull-up controls.
module gpio_cfg_pad #(
    parameter int unsigned NPINS = 8
) (
    input  logic [NPINS-1:0] den,
    input  logic [NPINS-1:0] pue,
    input  logic [NPINS-1:0] core_oe,
    output logic [NPINS-1:0] drv_en,
    output logic [NPINS-1:0] in_en,
    output logic [NPINS-1:0] pu_en
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign drv_en[p] = den[p] & core_oe[p];
        assign in_en[p]  = den[p];
        assign pu_en[p]  = pue[p];
    end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int unsigned      NPINS      = 8,
    parameter int unsigned      DW         = 32,
    parameter logic [NPINS-1:0] PROT_MASK  = 8'h80,
    parameter logic [DW-1:0]    UNLOCK_KEY = 32'h4C4F434B
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              pb_we,
    input  logic [REG_AW-1:0] pb_addr,
    input  logic [DW-1:0]     pb_wdata,
    input  logic              sb_we,
    input  logic [REG_AW-1:0] sb_addr,
    input  logic [DW-1:0]     sb_wdata,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NPINS-1:0]  core_oe,
    output logic [NPINS-1:0]  cfg_den,
    output logic [NPINS-1:0]  cfg_pue,
    output logic [NPINS-1:0]  cfg_afsel,
    output logic [NPINS-1:0]  cfg_csel,
    output logic [NPINS-1:0]  pad_drv_en,
    output logic [NPINS-1:0]  pad_in_en,
    output logic [NPINS-1:0]  pad_pu_en
);

    typedef struct packed {
        logic [NPINS-1:0] den;
        logic [NPINS-1:0] pue;
        logic [NPINS-1:0] afs;
        logic [NPINS-1:0] csel;
        logic [NPINS-1:0] commit;
        logic             unlocked;
    } bank_t;

    // Either reset source clears the whole bank.
    logic rst_n;
    assign rst_n = por_n & ext_rst_n;

    bank_t st_q, mid_d, st_d;

    logic              stg_vld;
    logic [REG_AW-1:0] stg_addr;
    logic [DW-1:0]     stg_data;
    logic [NPINS-1:0]  pb_old, pb_merged, sb_old, sb_merged;
    logic              lock_open;
    logic [NPINS-1:0]  commit_q;

    function automatic logic [NPINS-1:0] pick(input bank_t s, input logic [REG_AW-1:0] a);
        logic [NPINS-1:0] v;
        case (a)
            RI_DEN:  v = s.den;
            RI_PUE:  v = s.pue;
            RI_AFS:  v = s.afs;
            RI_CSEL: v = s.csel;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Applies one write; 'guarded' already has protected bits resolved.
    function automatic bank_t apply(input bank_t s, input logic we,
                                    input logic [REG_AW-1:0] a,
                                    input logic [NPINS-1:0] guarded,
                                    input logic [DW-1:0] raw);
        bank_t r;
        r = s;
        if (we) begin
            case (a)
                RI_DEN:    r.den      = guarded;
                RI_PUE:    r.pue      = guarded;
                RI_AFS:    r.afs      = guarded;
                RI_CSEL:   r.csel     = guarded;
                RI_LOCK:   r.unlocked = (raw == UNLOCK_KEY);
                RI_COMMIT: if (s.unlocked) r.commit = raw[NPINS-1:0];
                default:   ;
            endcase
        end
        return r;
    endfunction

    gpio_cfg_stage #(
        .AW (REG_AW),
        .DW (DW)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_we    (pb_we),
        .in_addr  (pb_addr),
        .in_data  (pb_wdata),
        .out_vld  (stg_vld),
        .out_addr (stg_addr),
        .out_data (stg_data)
    );

    // Staged peripheral write first, against the registered state.
    assign pb_old = pick(st_q, stg_addr);

    gpio_cfg_guard #(
        .NPINS     (NPINS),
        .PROT_MASK (PROT_MASK)
    ) u_guard_pb (
        .old_bits (pb_old),
        .new_bits (stg_data[NPINS-1:0]),
        .commit   (st_q.commit),
        .unlocked (st_q.unlocked),
        .merged   (pb_merged)
    );

    always_comb begin
        mid_d = apply(st_q, stg_vld, stg_addr, pb_merged, stg_data);
    end

    // System write second, against the state the staged write leaves.
    assign sb_old = pick(mid_d, sb_addr);

    gpio_cfg_guard #(
        .NPINS     (NPINS),
        .PROT_MASK (PROT_MASK)
    ) u_guard_sb (
        .old_bits (sb_old),
        .new_bits (sb_wdata[NPINS-1:0]),
        .commit   (mid_d.commit),
        .unlocked (mid_d.unlocked),
        .merged   (sb_merged)
    );

    always_comb begin
        st_d = apply(mid_d, sb_we, sb_addr, sb_merged, sb_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RI_LOCK:   rd_data[0]       = ~st_q.unlocked;
            RI_COMMIT: rd_data[NPINS-1:0] = st_q.commit;
            default:   rd_data[NPINS-1:0] = pick(st_q, rd_addr);
        endcase
    end

    assign cfg_den   = st_q.den;
    assign cfg_pue   = st_q.pue;
    assign cfg_afsel = st_q.afs;
    assign cfg_csel  = st_q.csel;
    assign lock_open = st_q.unlocked;
    assign commit_q  = st_q.commit;

    gpio_cfg_pad #(
        .NPINS (NPINS)
    ) u_pad (
        .den     (st_q.den),
        .pue     (st_q.pue),
        .core_oe (core_oe),
        .drv_en  (pad_drv_en),
        .in_en   (pad_in_en),
        .pu_en   (pad_pu_en)
    );

endmodule

// File: rtl/gpio_cfg_chk.sv
module gpio_cfg_chk
    import gpio_cfg_pkg::*;
#(
    parameter int unsigned      NPINS     = 8,
    parameter logic [NPINS-1:0] PROT_MASK = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stg_pending,
    input logic              lock_open,
    input logic [NPINS-1:0]  commit,
    input logic [NPINS-1:0]  den,
    input logic [NPINS-1:0]  pue,
    input logic [NPINS-1:0]  afs,
    input logic [NPINS-1:0]  csel,
    input logic [NPINS-1:0]  drv_en,
    input logic [NPINS-1:0]  in_en,
    input logic              sb_we,
    input logic [REG_AW-1:0] sb_addr,
    input logic [NPINS-1:0]  sb_wdata,
    input logic              pb_we,
    input logic [REG_AW-1:0] pb_addr,
    input logic [NPINS-1:0]  pb_wdata
);

    // R3: no pad function on a pin whose digital enable is clear
    p_pad_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_en | in_en) & ~den) == '0);

    // R8: protected bits hold while locked with nothing staged
    p_prot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stg_pending && !lock_open) |=>
        ((((den ^ $past(den)) | (pue ^ $past(pue)) |
           (afs ^ $past(afs)) | (csel ^ $past(csel))) & PROT_MASK) == '0));

    // R7: commit mask holds while locked with nothing staged
    p_commit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stg_pending && !lock_open) |=> $stable(commit));

    // R10: system-path write visible one edge later on unprotected bits
    p_sb_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_we && sb_addr == RI_DEN) |=>
        (((den ^ $past(sb_wdata)) & ~PROT_MASK) == '0));

    // R11: peripheral-path write visible two edges later on unprotected bits
    p_pb_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pb_we, 2) && $past(pb_addr, 2) == RI_DEN &&
         !($past(sb_we) && $past(sb_addr) == RI_DEN)) |->
        (((den ^ $past(pb_wdata, 2)) & ~PROT_MASK) == '0));

endmodule

bind gpio_cfg_bank gpio_cfg_chk #(
    .NPINS     (NPINS),
    .PROT_MASK (PROT_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stg_pending (stg_vld),
    .lock_open   (lock_open),
    .commit      (commit_q),
    .den         (cfg_den),
    .pue         (cfg_pue),
    .afs         (cfg_afsel),
    .csel        (cfg_csel),
    .drv_en      (pad_drv_en),
    .in_en       (pad_in_en),
    .sb_we       (sb_we),
    .sb_addr     (sb_addr),
    .sb_wdata    (sb_wdata[NPINS-1:0]),
    .pb_we       (pb_we),
    .pb_addr     (pb_addr),
    .pb_wdata    (pb_wdata[NPINS-1:0])
);

// File: tb/gpio_cfg_bank_tb.sv
module gpio_cfg_bank_tb;

    localparam logic [31:0] KEY = 32'h4C4F434B;
    localparam logic [2:0] A_DEN = 3'd0, A_PUE = 3'd1, A_AFS = 3'd2,
                           A_CSEL = 3'd3, A_LOCK = 3'd4, A_COMMIT = 3'd5;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, ext_rst_n = 1'b0;
    logic        pb_we = 1'b0, sb_we = 1'b0;
    logic [2:0]  pb_addr = '0, sb_addr = '0, rd_addr = '0;
    logic [31:0] pb_wdata = '0, sb_wdata = '0;
    logic [31:0] rd_data;
    logic [7:0]  core_oe = '0;
    logic [7:0]  cfg_den, cfg_pue, cfg_afsel, cfg_csel;
    logic [7:0]  pad_drv_en, pad_in_en, pad_pu_en;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    gpio_cfg_bank u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .core_oe(core_oe),
        .cfg_den(cfg_den), .cfg_pue(cfg_pue), .cfg_afsel(cfg_afsel),
        .cfg_csel(cfg_csel), .pad_drv_en(pad_drv_en),
        .pad_in_en(pad_in_en), .pad_pu_en(pad_pu_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // Returns at the negedge after the sampling edge: result already visible.
    task automatic sb_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sb_we = 1'b1; sb_addr = a; sb_wdata = d;
        @(negedge clk);
        sb_we = 1'b0;
    endtask

    // Returns at the negedge after the sampling edge: result not yet applied.
    task automatic pb_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        pb_we = 1'b1; pb_addr = a; pb_wdata = d;
        @(negedge clk);
        pb_we = 1'b0;
    endtask

    task automatic check_defaults(input string tag);
        for (int r = 0; r < 4; r++) rd_chk(tag, 3'(r), 32'h0);
        rd_chk(tag, A_LOCK, 32'h1);
        rd_chk(tag, A_COMMIT, 32'h0);
        chk(tag, {cfg_den, cfg_pue, cfg_afsel, cfg_csel}, 32'h0);
    endtask

    task automatic t_reset;   // R1
        check_defaults("R1 reset defaults");
        chk("R1 pad outputs", {8'h0, pad_drv_en, pad_in_en, pad_pu_en}, 32'h0);
    endtask

    task automatic t_pad;     // R3 R4
        core_oe = 8'h33;
        sb_wr(A_DEN, 32'h0F);
        sb_wr(A_PUE, 32'h5A);
        chk("R3 drive enable", {24'h0, pad_drv_en}, 32'h03);
        chk("R3 input enable", {24'h0, pad_in_en}, 32'h0F);
        chk("R4 pull-up", {24'h0, pad_pu_en}, 32'h5A);
        sb_wr(A_DEN, 32'h00);
        chk("R3 disabled pins", {16'h0, pad_drv_en, pad_in_en}, 32'h0);
    endtask

    task automatic t_width;   // R5
        sb_wr(A_AFS, 32'hFFFF_FF3C);
        rd_chk("R5 upper bits read 0", A_AFS, 32'h3C);
        chk("R5 afsel output", {24'h0, cfg_afsel}, 32'h3C);
        rd_chk("R5 index 6 reads 0", 3'd6, 32'h0);
        rd_chk("R5 index 7 reads 0", 3'd7, 32'h0);
    endtask

    task automatic t_lock;    // R6
        sb_wr(A_LOCK, KEY);
        rd_chk("R6 key unlocks", A_LOCK, 32'h0);
        sb_wr(A_LOCK, 32'h1234);
        rd_chk("R6 other value locks", A_LOCK, 32'h1);
    endtask

    task automatic t_commit;  // R7
        sb_wr(A_COMMIT, 32'h80);
        rd_chk("R7 commit blocked while locked", A_COMMIT, 32'h0);
        sb_wr(A_LOCK, KEY);
        sb_wr(A_COMMIT, 32'h80);
        rd_chk("R7 commit written while unlocked", A_COMMIT, 32'h80);
        sb_wr(A_LOCK, 32'h0);
        sb_wr(A_COMMIT, 32'h00);
        rd_chk("R7 commit held after relock", A_COMMIT, 32'h80);
    endtask

    task automatic t_prot;    // R2 R8 R9
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk); ext_rst_n = 1'b1;
        check_defaults("R2 external reset");
        for (int r = 0; r < 4; r++) begin
            sb_wr(3'(r), 32'hFF);
            rd_chk("R8 locked, commit 0", 3'(r), 32'h7F);
        end
        sb_wr(A_LOCK, KEY);
        for (int r = 0; r < 4; r++) begin
            sb_wr(3'(r), 32'hFF);
            rd_chk("R8 unlocked, commit 0", 3'(r), 32'h7F);
        end
        sb_wr(A_COMMIT, 32'h80);
        sb_wr(A_LOCK, 32'h0);
        for (int r = 0; r < 4; r++) begin
            sb_wr(3'(r), 32'hFF);
            rd_chk("R8 locked, commit 1", 3'(r), 32'h7F);
        end
        sb_wr(A_LOCK, KEY);
        for (int r = 0; r < 4; r++) begin
            sb_wr(3'(r), 32'hFF);
            rd_chk("R8 unlocked, commit 1", 3'(r), 32'hFF);
        end
        sb_wr(A_LOCK, 32'h0);
        for (int r = 0; r < 4; r++) begin
            sb_wr(3'(r), 32'h00);
            rd_chk("R9 low bits written, pin 7 kept", 3'(r), 32'h80);
        end
    endtask

    task automatic t_lat;     // R10 R11  (locked, csel = 0x80)
        sb_wr(A_CSEL, 32'h11);
        chk("R10 system path after one edge", {24'h0, cfg_csel}, 32'h91);
        pb_wr(A_CSEL, 32'h22);
        chk("R11 peripheral path not after one edge", {24'h0, cfg_csel}, 32'h91);
        rd_chk("R11 read not after one edge", A_CSEL, 32'h91);
        @(negedge clk);
        chk("R11 peripheral path after two edges", {24'h0, cfg_csel}, 32'hA2);
    endtask

    task automatic t_order;   // R12 (locked, commit 0x80, den = 0x80)
        @(negedge clk);
        pb_we = 1'b1; pb_addr = A_DEN; pb_wdata = 32'h01;
        @(negedge clk);
        pb_we = 1'b0;
        sb_we = 1'b1; sb_addr = A_DEN; sb_wdata = 32'h02;
        @(negedge clk);
        sb_we = 1'b0;
        chk("R12 system write wins same edge", {24'h0, cfg_den}, 32'h82);
        @(negedge clk);
        pb_we = 1'b1; pb_addr = A_LOCK; pb_wdata = KEY;
        @(negedge clk);
        pb_we = 1'b0;
        sb_we = 1'b1; sb_addr = A_DEN; sb_wdata = 32'h00;
        @(negedge clk);
        sb_we = 1'b0;
        chk("R12 staged unlock applies first", {24'h0, cfg_den}, 32'h00);
        rd_chk("R12 lock open after staged key", A_LOCK, 32'h0);
    endtask

    task automatic t_por;     // R2
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        check_defaults("R2 power-on reset");
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        ext_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pad();
        t_width();
        t_lock();
        t_commit();
        t_prot();
        t_lat();
        t_order();
        t_por();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule